// File: doc/BRIEF.md
# Equalizer Boost Adaptation Controller

This block tunes a 4-bit receive equalizer boost setting while live data is being received. Each sample period it may receive a sample-valid strobe, the slicer's one-bit decision (1 for the positive symbol) and the signed slicer voltage at the decision point. It counts valid samples to find symbol boundaries. At each boundary it forms a three-symbol window from the two previous decisions and the newest one. Steady windows (111, 000) are low-frequency events. Alternating windows (010, 101) are high-frequency events. For each event the block adds the magnitude of the middle symbol's voltage to a per-class sum and increments a per-class count.

After a fixed number of symbols the controller compares the two class averages. If the low-frequency average is strictly larger, the boost goes up by one. In every other case it goes down by one. Either way, both sums and both counts start again from zero. Steps are kept inside 0..15. A four-deep record of applied steps acts as a watchdog: once the record shows the setting bouncing back and forth, the next bouncing step is refused and the setting is frozen for good.

The control is a three-state machine. S_ACQ accumulates events and moves to S_EVAL on the symbol that completes an update interval. S_EVAL applies or skips one step and returns to S_ACQ, or moves to S_LOCK when the watchdog refuses a step. S_LOCK holds until a reset or start pulse, which returns the machine to S_ACQ from any state.

Top module: `eq_boost_adapt`

## Requirements
- R1: While enabled, a symbol boundary occurs on every SPS-th sample that has `smp_valid` high. Samples with `smp_valid` low advance nothing and their slicer inputs are ignored.
- R2: A window is classified only once three symbols have been received since the last reset or start. Decisions left from before a reset or start never form part of a window.
- R3: The window is {older, middle, newest}. 111 or 000 adds |middle voltage| to the low sum and increments the low count. 010 or 101 does the same for the high sum and high count. All other windows change neither class.
- R4: On every UPDATE_SYMS-th symbol boundary exactly one evaluation takes place, and it uses all events up to and including that boundary. The step is up when low_sum*high_count > high_sum*low_count, and down otherwise, including on a tie.
- R5: If either event count is zero at an evaluation, no step is taken.
- R6: After every evaluation, both counts and both sums restart from zero, whatever the outcome of the evaluation.
- R7: `boost_set` stays within 0..15 and changes by at most one per evaluation. A step that would leave the range is skipped, is not recorded in the step history, and does not lock.
- R8: The step history holds the last four applied steps, oldest first, and starts empty. A step up is refused when the history reads up,down,up,down, and a step down is refused when it reads down,up,down,up. A refusal enters S_LOCK. While locked, `boost_set` is frozen and no evaluation occurs.
- R9: Adaptation runs only while `mode` equals 2'd2. Any other mode value freezes the sample counter, the symbol counter, the windows, the sums and `boost_set`.
- R10: A synchronous `rst` or a `start` pulse clears the counters, the histories and the lock, and loads `init_set` into `boost_set`.
- R11: `boost_set` is registered. It still holds its old value in the cycle after the clock edge that captures the interval's last boundary sample, and shows the new value one cycle later.
- R12: A voltage of -2048 counts as magnitude 2048. The sums hold UPDATE_SYMS such magnitudes without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Restart pulse: clears adaptation state and reloads the initial setting |
| mode | input | 2 | Operating mode; 2'd2 enables adaptation |
| init_set | input | 4 | Initial boost setting |
| smp_valid | input | 1 | Marks a valid slicer sample this cycle |
| slc_bit | input | 1 | Slicer decision, 1 = positive symbol |
| slc_volt | input | 12 | Signed slicer voltage at the decision point |
| boost_set | output | 4 | Current equalizer boost setting |

## Verification
The bench builds the block with SPS = 2 and UPDATE_SYMS = 8. A full evaluation interval is then only a few dozen cycles, so the bench can reach these cases many times over:
- climbs to both range limits;
- both watchdog refusal patterns and the lock that follows;
- restarts from many initial settings;
- a few hundred randomized intervals with sample gaps, mode changes and extreme voltages.

At every interval end the bench compares `boost_set` with an arithmetic model of the averaging rule. For the intervals that evaluate, it also checks the two-cycle output timing.

// File: rtl/eqa_pkg.sv
package eqa_pkg;

    // One entry of the applied-step record
    typedef enum logic [1:0] {
        STEP_NONE = 2'b00,
        STEP_UP   = 2'b01,
        STEP_DN   = 2'b11
    } step_e;

    // Controller states
    typedef enum logic [1:0] {
        S_ACQ  = 2'b00,
        S_EVAL = 2'b01,
        S_LOCK = 2'b10
    } ctrl_state_e;

    // Mode value that enables adaptation
    localparam logic [1:0] MODE_ADAPT = 2'd2;

endpackage

// File: rtl/eqa_symbol_timer.sv
module eqa_symbol_timer #(
    parameter int SPS         = 8,
    parameter int UPDATE_SYMS = 1000
) (
    input  logic clk,
    input  logic clr,
    input  logic en,
    input  logic smp_valid,
    output logic sym_tick,
    output logic upd_tick
);
    localparam int SCW = (SPS > 1) ? $clog2(SPS) : 1;
    localparam int UCW = (UPDATE_SYMS > 1) ? $clog2(UPDATE_SYMS) : 1;
    localparam logic [SCW-1:0] SAMP_LAST = SCW'(SPS - 1);
    localparam logic [UCW-1:0] SYM_LAST  = UCW'(UPDATE_SYMS - 1);

    logic [SCW-1:0] samp_q;
    logic [UCW-1:0] sym_q;
    logic           samp_go;

    assign samp_go  = en && smp_valid;
    assign sym_tick = samp_go && (samp_q == SAMP_LAST);
    assign upd_tick = sym_tick && (sym_q == SYM_LAST);

    // Samples within the current symbol
    always_ff @(posedge clk) begin
        if (clr) begin
            samp_q <= '0;
        end else if (samp_go) begin
            if (samp_q == SAMP_LAST) begin
                samp_q <= '0;
            end else begin
                samp_q <= samp_q + SCW'(1);
            end
        end
    end

    // Symbols within the current update interval
    always_ff @(posedge clk) begin
        if (clr) begin
            sym_q <= '0;
        end else if (sym_tick) begin
            if (upd_tick) begin
                sym_q <= '0;
            end else begin
                sym_q <= sym_q + UCW'(1);
            end
        end
    end

endmodule

// File: rtl/eqa_pattern_acc.sv
module eqa_pattern_acc #(
    parameter int VW   = 12,
    parameter int CNTW = 10,
    parameter int SUMW = 22
) (
    input  logic                 clk,
    input  logic                 clr,
    input  logic                 sym_tick,
    input  logic                 slc_bit,
    input  logic signed [VW-1:0] slc_volt,
    input  logic                 acc_clr,
    output logic [CNTW-1:0]      lo_cnt,
    output logic [CNTW-1:0]      hi_cnt,
    output logic [SUMW-1:0]      lo_sum,
    output logic [SUMW-1:0]      hi_sum
);
    localparam int NCLS = 2;   // class 0 = steady, class 1 = alternating

    logic [1:0]           bit_h;     // [1] older, [0] middle
    logic signed [VW-1:0] vmid_q;    // voltage of the middle symbol
    logic [1:0]           fill_q;    // symbols seen, saturating at 2
    logic                 full;
    logic [VW-1:0]        mag;
    logic [NCLS-1:0]      hit;
    logic [CNTW-1:0]      cnt_q [NCLS];
    logic [SUMW-1:0]      sum_q [NCLS];

    assign full = (fill_q == 2'd2);
    assign mag  = vmid_q[VW-1] ? VW'(-vmid_q) : VW'(vmid_q);

    assign hit[0] = full && (bit_h[1] == bit_h[0]) && (bit_h[0] == slc_bit);
    assign hit[1] = full && (bit_h[1] == slc_bit) && (bit_h[0] != slc_bit);

    // Decision and voltage history
    always_ff @(posedge clk) begin
        if (clr) begin
            bit_h  <= '0;
            vmid_q <= '0;
            fill_q <= '0;
        end else if (sym_tick) begin
            bit_h  <= {bit_h[0], slc_bit};
            vmid_q <= slc_volt;
            if (!full) begin
                fill_q <= fill_q + 2'd1;
            end
        end
    end

    // One counter and one magnitude sum per class
    for (genvar g = 0; g < NCLS; g++) begin : g_cls
        logic take;
        assign take = sym_tick && hit[g];

        always_ff @(posedge clk) begin
            if (clr) begin
                cnt_q[g] <= '0;
                sum_q[g] <= '0;
            end else if (acc_clr) begin
                cnt_q[g] <= take ? CNTW'(1) : '0;
                sum_q[g] <= take ? SUMW'(mag) : '0;
            end else if (take) begin
                cnt_q[g] <= cnt_q[g] + CNTW'(1);
                sum_q[g] <= sum_q[g] + SUMW'(mag);
            end
        end
    end

    assign lo_cnt = cnt_q[0];
    assign hi_cnt = cnt_q[1];
    assign lo_sum = sum_q[0];
    assign hi_sum = sum_q[1];

endmodule

// File: rtl/eqa_step_ctrl.sv
module eqa_step_ctrl
    import eqa_pkg::*;
#(
    parameter int SETW = 4,
    parameter int CNTW = 10,
    parameter int SUMW = 22
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [1:0]      mode,
    input  logic [SETW-1:0] init_set,
    input  logic            upd_tick,
    input  logic [CNTW-1:0] lo_cnt,
    input  logic [CNTW-1:0] hi_cnt,
    input  logic [SUMW-1:0] lo_sum,
    input  logic [SUMW-1:0] hi_sum,
    output logic [SETW-1:0] boost_set,
    output logic            adapt_en,
    output logic            eval_stb,
    output logic            locked
);
    localparam int PW    = SUMW + CNTW;
    localparam int HDEPTH = 4;
    localparam logic [SETW-1:0] SET_MAX = {SETW{1'b1}};

    ctrl_state_e     state_q, state_d;
    step_e           hist_q [HDEPTH];   // index 0 = oldest
    logic [SETW-1:0] set_q;

    logic [PW-1:0] lhs, rhs;
    logic          both_seen, want_up, room_up, room_dn;
    logic          refuse_up, refuse_dn;
    logic          do_inc, do_dec, trip;

    // Average comparison without division
    assign lhs       = PW'(lo_sum) * PW'(hi_cnt);
    assign rhs       = PW'(hi_sum) * PW'(lo_cnt);
    assign both_seen = (lo_cnt != '0) && (hi_cnt != '0);
    assign want_up   = lhs > rhs;
    assign room_up   = set_q != SET_MAX;
    assign room_dn   = set_q != '0;

    assign refuse_up = (hist_q[0] == STEP_UP) && (hist_q[1] == STEP_DN) &&
                       (hist_q[2] == STEP_UP) && (hist_q[3] == STEP_DN);
    assign refuse_dn = (hist_q[0] == STEP_DN) && (hist_q[1] == STEP_UP) &&
                       (hist_q[2] == STEP_DN) && (hist_q[3] == STEP_UP);

    assign eval_stb = (state_q == S_EVAL);
    assign do_inc   = eval_stb && both_seen &&  want_up && room_up && !refuse_up;
    assign do_dec   = eval_stb && both_seen && !want_up && room_dn && !refuse_dn;
    assign trip     = eval_stb && both_seen &&
                      (( want_up && room_up && refuse_up) ||
                       (!want_up && room_dn && refuse_dn));

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_ACQ:   state_d = upd_tick ? S_EVAL : S_ACQ;
            S_EVAL:  state_d = trip ? S_LOCK : S_ACQ;
            S_LOCK:  state_d = S_LOCK;
            default: state_d = S_ACQ;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst || start) begin
            state_q <= S_ACQ;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs: setting and step record
    always_ff @(posedge clk) begin
        if (rst || start) begin
            set_q <= init_set;
            for (int i = 0; i < HDEPTH; i++) begin
                hist_q[i] <= STEP_NONE;
            end
        end else if (do_inc || do_dec) begin
            set_q <= do_inc ? set_q + SETW'(1) : set_q - SETW'(1);
            for (int i = 0; i < HDEPTH - 1; i++) begin
                hist_q[i] <= hist_q[i+1];
            end
            hist_q[HDEPTH-1] <= do_inc ? STEP_UP : STEP_DN;
        end
    end

    assign boost_set = set_q;
    assign locked    = (state_q == S_LOCK);
    assign adapt_en  = (mode == MODE_ADAPT) && !locked;

endmodule

// File: rtl/eq_boost_adapt.sv
module eq_boost_adapt #(
    parameter int SPS         = 8,
    parameter int UPDATE_SYMS = 1000,
    parameter int VW          = 12,
    parameter int SETW        = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [1:0]           mode,
    input  logic [SETW-1:0]      init_set,
    input  logic                 smp_valid,
    input  logic                 slc_bit,
    input  logic signed [VW-1:0] slc_volt,
    output logic [SETW-1:0]      boost_set
);
    localparam int CNTW = $clog2(UPDATE_SYMS + 1);
    localparam int SUMW = VW + CNTW;

    logic            clr_all;
    logic            adapt_en, sym_tick, upd_tick, eval_stb, locked;
    logic [CNTW-1:0] lo_cnt, hi_cnt;
    logic [SUMW-1:0] lo_sum, hi_sum;

    assign clr_all = rst || start;

    eqa_symbol_timer #(
        .SPS         (SPS),
        .UPDATE_SYMS (UPDATE_SYMS)
    ) u_timer (
        .clk       (clk),
        .clr       (clr_all),
        .en        (adapt_en),
        .smp_valid (smp_valid),
        .sym_tick  (sym_tick),
        .upd_tick  (upd_tick)
    );

    eqa_pattern_acc #(
        .VW   (VW),
        .CNTW (CNTW),
        .SUMW (SUMW)
    ) u_acc (
        .clk      (clk),
        .clr      (clr_all),
        .sym_tick (sym_tick),
        .slc_bit  (slc_bit),
        .slc_volt (slc_volt),
        .acc_clr  (eval_stb),
        .lo_cnt   (lo_cnt),
        .hi_cnt   (hi_cnt),
        .lo_sum   (lo_sum),
        .hi_sum   (hi_sum)
    );

    eqa_step_ctrl #(
        .SETW (SETW),
        .CNTW (CNTW),
        .SUMW (SUMW)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode      (mode),
        .init_set  (init_set),
        .upd_tick  (upd_tick),
        .lo_cnt    (lo_cnt),
        .hi_cnt    (hi_cnt),
        .lo_sum    (lo_sum),
        .hi_sum    (hi_sum),
        .boost_set (boost_set),
        .adapt_en  (adapt_en),
        .eval_stb  (eval_stb),
        .locked    (locked)
    );

endmodule

// File: rtl/eqa_adapt_chk.sv
module eqa_adapt_chk #(
    parameter int SETW = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [1:0]      mode,
    input logic [SETW-1:0] boost_set,
    input logic            sym_tick,
    input logic            eval_stb,
    input logic            locked
);
    // R7: at most one step per cycle
    assert_unit_step_R7: assert property (@(posedge clk) disable iff (rst)
        !start |=> (({1'b0, boost_set} == {1'b0, $past(boost_set)}) ||
                    ({1'b0, boost_set} == {1'b0, $past(boost_set)} + 1'b1) ||
                    ({1'b0, boost_set} + 1'b1 == {1'b0, $past(boost_set)})));

    // R11: the setting moves only in the cycle after an evaluation
    assert_move_after_eval_R11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(start) && (boost_set != $past(boost_set)))
            |-> $past(eval_stb));

    // R8: the lock is sticky until a restart
    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (locked && !start) |=> locked);

    // R8: a locked setting is frozen
    assert_lock_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (locked && !start) |=> $stable(boost_set));

    // R9: no symbol progress outside the adapt mode
    assert_mode_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd2) |-> !sym_tick);

    // R4: an evaluation follows a symbol boundary
    assert_eval_on_boundary_R4: assert property (@(posedge clk) disable iff (rst)
        eval_stb |-> $past(sym_tick));

endmodule

bind eq_boost_adapt eqa_adapt_chk #(.SETW(SETW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mode      (mode),
    .boost_set (boost_set),
    .sym_tick  (sym_tick),
    .eval_stb  (eval_stb),
    .locked    (locked)
);

// File: tb/sim_eq_boost_adapt.sv
module sim_eq_boost_adapt;
    localparam int SPS = 2;
    localparam int UPD = 8;

    logic              clk = 1'b0;
    logic              rst, start, smp_valid, slc_bit;
    logic [1:0]        mode;
    logic [3:0]        init_set;
    logic signed [11:0] slc_volt;
    logic [3:0]        boost_set;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model state
    int     m_set, m_prev, m_lock, m_fill, m_b1, m_b0, m_vmid, m_sym, m_evald;
    int     m_lc, m_hc;
    longint m_ls, m_hs;
    int     m_h [4];
    int     last_bit;

    always #2ns clk = ~clk;

    eq_boost_adapt #(.SPS(SPS), .UPDATE_SYMS(UPD), .VW(12), .SETW(4)) u0 (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .init_set(init_set),
        .smp_valid(smp_valid), .slc_bit(slc_bit), .slc_volt(slc_volt),
        .boost_set(boost_set)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear(input int init);
        m_set = init; m_prev = init; m_lock = 0; m_fill = 0; m_b1 = 0; m_b0 = 0;
        m_vmid = 0; m_sym = 0; m_lc = 0; m_hc = 0; m_ls = 0; m_hs = 0;
        for (int i = 0; i < 4; i++) m_h[i] = 0;
    endtask

    task automatic push_step(input int s);
        for (int i = 0; i < 3; i++) m_h[i] = m_h[i+1];
        m_h[3] = s;
    endtask

    task automatic model_eval();
        bit up;
        m_prev  = m_set;
        m_evald = 1;
        if (m_lc > 0 && m_hc > 0) begin
            up = (m_ls * m_hc) > (m_hs * m_lc);
            if (up && m_set < 15) begin
                if (m_h[0] == 1 && m_h[1] == -1 && m_h[2] == 1 && m_h[3] == -1) m_lock = 1;
                else begin m_set++; push_step(1); end
            end else if (!up && m_set > 0) begin
                if (m_h[0] == -1 && m_h[1] == 1 && m_h[2] == -1 && m_h[3] == 1) m_lock = 1;
                else begin m_set--; push_step(-1); end
            end
        end
        m_lc = 0; m_hc = 0; m_ls = 0; m_hs = 0;
    endtask

    task automatic model_symbol(input int b, input int v);
        int mag;
        if (mode != 2'd2 || m_lock != 0) return;
        if (m_fill == 2) begin
            mag = (m_vmid < 0) ? -m_vmid : m_vmid;
            if (m_b1 == m_b0 && m_b0 == b) begin m_lc++; m_ls += mag; end
            else if (m_b1 == b && m_b0 != b) begin m_hc++; m_hs += mag; end
        end
        m_b1 = m_b0; m_b0 = b; m_vmid = v;
        if (m_fill < 2) m_fill++;
        m_sym++;
        if (m_sym == UPD) begin m_sym = 0; model_eval(); end
    endtask

    // one symbol: SPS valid samples, optional invalid gaps with junk data
    task automatic send_symbol(input int b, input int v, input bit gaps);
        for (int s = 0; s < SPS; s++) begin
            if (gaps && ($urandom_range(0, 3) == 0)) begin
                @(negedge clk);
                smp_valid = 1'b0;
                slc_bit   = ~b[0];
                slc_volt  = 12'sh7ff;
            end
            @(negedge clk);
            smp_valid = 1'b1;
            slc_bit   = b[0];
            slc_volt  = 12'(v);
        end
        m_evald = 0;
        model_symbol(b, v);
        if (m_evald != 0) begin
            @(negedge clk);
            smp_valid = 1'b0;
            chk("R11 old value held", int'(boost_set), m_prev);
            @(negedge clk);
            chk("R4 stepped value", int'(boost_set), m_set);
        end
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        smp_valid = 1'b0;
        chk(req, int'(boost_set), m_set);
    endtask

    // one interval whose windows take steady magnitude lfv and alternating magnitude hfv
    task automatic run_interval(input int lfv, input int hfv, input string req);
        int seq [8] = '{1, 1, 1, 0, 1, 0, 0, 0};
        int mag, v;
        for (int k = 0; k < UPD; k++) begin
            mag = (seq[k] == last_bit) ? lfv : hfv;
            v   = (mag == 2048) ? -2048 : ((seq[k] != 0) ? mag : -mag);
            send_symbol(seq[k], v, 1'b0);
            last_bit = seq[k];
        end
        idle_check(req);
    endtask

    task automatic do_start(input int init);
        @(negedge clk);
        smp_valid = 1'b0;
        init_set  = 4'(init);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        model_clear(init);
        chk("R10 start reloads", int'(boost_set), init);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; mode = 2'd2; init_set = 4'd3;
        smp_valid = 1'b0; slc_bit = 1'b0; slc_volt = '0;
        last_bit = 0;
        model_clear(3);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset value", int'(boost_set), 3);

        // R2 / R5: alternating bits only -> no steady event -> no step
        for (int k = 0; k < UPD; k++) send_symbol(k % 2, 300, 1'b0);
        last_bit = (UPD - 1) % 2;
        idle_check("R2 R5 no steady events");
        chk("R5 setting kept", int'(boost_set), 3);

        // R3 / R4 / R7: climb to the top and saturate
        for (int i = 0; i < 15; i++) run_interval(900, 100, "R3 R7 climb");
        chk("R7 upper limit", int'(boost_set), 15);
        // R6: sums cleared -> the very next interval decides on its own data
        run_interval(50, 1500, "R6 cleared sums");
        chk("R6 down after clear", int'(boost_set), 14);
        // R4 tie goes down
        run_interval(400, 400, "R4 tie steps down");
        chk("R4 tie", int'(boost_set), 13);

        // R7 lower limit and no lock from skipped steps
        do_start(2);
        for (int i = 0; i < 5; i++) run_interval(100, 900, "R7 descend");
        chk("R7 lower limit", int'(boost_set), 0);
        run_interval(900, 100, "R7 not locked after skips");
        chk("R7 steps after floor", int'(boost_set), 1);

        // R8: oscillation up,down,up,down then up refused
        do_start(7);
        run_interval(900, 100, "R8 up");
        run_interval(100, 900, "R8 down");
        run_interval(900, 100, "R8 up");
        run_interval(100, 900, "R8 down");
        run_interval(900, 100, "R8 refused up");
        chk("R8 locked value", int'(boost_set), 7);
        run_interval(900, 100, "R8 frozen");
        run_interval(100, 900, "R8 frozen");
        chk("R8 still frozen", int'(boost_set), 7);

        // R8: mirrored pattern, down refused
        do_start(9);
        run_interval(100, 900, "R8 down");
        run_interval(900, 100, "R8 up");
        run_interval(100, 900, "R8 down");
        run_interval(900, 100, "R8 up");
        run_interval(100, 900, "R8 refused down");
        chk("R8 mirrored lock", int'(boost_set), 9);

        // R9: other modes freeze everything
        do_start(5);
        mode = 2'd1;
        run_interval(900, 100, "R9 mode 1 frozen");
        mode = 2'd0;
        run_interval(900, 100, "R9 mode 0 frozen");
        chk("R9 unchanged", int'(boost_set), 5);
        mode = 2'd2;
        run_interval(900, 100, "R9 resumes");
        chk("R9 resumed step", int'(boost_set), 6);

        // R12: extreme magnitude 2048 versus 2047
        do_start(4);
        run_interval(2048, 2047, "R12 extreme magnitude");
        chk("R12 up on 2048", int'(boost_set), 5);

        // R1 R3 R4: randomized sweep with gaps, mode changes and restarts
        for (int n = 0; n < 300; n++) begin
            if (n % 25 == 0) do_start($urandom_range(0, 15));
            mode = ($urandom_range(0, 9) < 8) ? 2'd2 : 2'($urandom_range(0, 3));
            for (int k = 0; k < UPD; k++) begin
                int b, v;
                b = $urandom_range(0, 1);
                v = ($urandom_range(0, 15) == 0) ? -2048 : int'($urandom_range(0, 4095)) - 2048;
                send_symbol(b, v, 1'b1);
            end
            idle_check("R1 R3 sweep");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule